// File: doc/BRIEF.md
# Fracturable LUT Logic Cell

This block is one element of a soft programmable-fabric model. It holds two lookup-table halves, two dedicated full adders and two flip-flops. All of its behaviour comes from a static configuration word. Four data pins feed both halves, and each half has two more pins of its own. With these pins the cell can act as two independent small functions, as a single function of up to six inputs, or as a selection between two six-input tables that share five inputs.

In arithmetic mode, each half splits its table into two operand bits. These feed a full adder. Carry ripples from the cell's carry input through half 0 and then half 1. A second ripple path, the share chain, lets the tables act as a 3:2 compressor, so that a three-operand sum can be built across a column of cells. Each flip-flop loads from one of three sources: the logic result, the adder sum, or the register chain. Chained cells therefore form a shift path two stages deep per cell. Each half's routed output is either its combinational value or its register.

Top module: `flc_cell`

## Requirements
- R1: While `rst_n` is low, `q` and `chain_out` are 0, whatever the enables, clears and data inputs are.
- R2: Configuration layout, with the default K=6 and N = 2^K = 64:
  - `cfg[N-1:0]` is table 0 and `cfg[2N-1:N]` is table 1.
  - `cfg[2N+h]` is the arithmetic bit of half h.
  - `cfg[2N+2+2h +: 2]` is the register source of half h.
  - `cfg[2N+6+h]` is the output-register bit of half h.
  - `cfg[2N+8]` is the fuse bit and `cfg[2N+9]` is the share bit.

  In logic mode, with the fuse bit off, `y[h]` equals bit `{din_f[h], din_e[h], din_s}` of table h, where `din_s[0]` is the least significant address bit.
- R3: If a table repeats the same 16-bit pattern four times, `y[h]` depends only on `din_s`. Changing `din_e` or `din_f` has no effect. This gives two independent 4-input functions.
- R4: With the fuse bit set, `y[0]` equals table 1 at address `{din_e[1], din_e[0], din_s}` when `din_f[1]` is 1. When `din_f[1]` is 0, `y[0]` equals table 0 at address `{din_f[0], din_e[0], din_s}`. `y[1]` is unaffected.
- R5: In arithmetic mode, half h takes operand A from table bit `{0, din_e[h], din_s}` and operand B from table bit `{1, din_e[h], din_s}`. It adds them to its incoming carry. `y[h]` is the sum bit. Carry runs from `carry_in` through half 0, then half 1, and leaves on `carry_out`.
- R6: With the share bit set, each adder's operand B is replaced by the share-chain bit entering that half. Half 0 receives `share_in`, half 1 receives operand B of half 0, and `share_out` carries operand B of half 1. With the share bit clear, `share_out` is 0.
- R7: At a rising clock edge with the enable high, register h loads according to its source code: 0 loads the logic result (the fused value for half 0 when fused), 1 loads the adder sum, and 2 or 3 loads the chain input.
- R8: With the chain source selected, register 0 loads `chain_in`, register 1 loads register 0, and `chain_out` equals register 1.
- R9: A high `sclr[h]` clears register h to 0 at the next edge, even when `en[h]` is low.
- R10: With `en[h]` and `sclr[h]` both low, register h holds its value.
- R11: With the output-register bit of half h set, `y[h]` equals `q[h]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock shared by both registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 2^(K+1)+10 | Static configuration word |
| din_s | input | K-2 | Data pins shared by both halves |
| din_e | input | 2 | Private e pin of each half |
| din_f | input | 2 | Private f pin of each half |
| carry_in | input | 1 | Carry entering half 0 |
| carry_out | output | 1 | Carry leaving half 1 |
| share_in | input | 1 | Share-chain bit entering half 0 |
| share_out | output | 1 | Share-chain bit leaving half 1 |
| chain_in | input | 1 | Register-chain input |
| chain_out | output | 1 | Register-chain output |
| en | input | 2 | Per-register clock enable |
| sclr | input | 2 | Per-register synchronous clear |
| y | output | 2 | Routed output of each half |
| q | output | 2 | Register output of each half |

## Verification
The hardest state to reach is one where the share chain and the carry chain are both active. Here half 1's adder sees operand B from half 0's table, not from its own. A mistake in the order of the ripple therefore shows up only when the two tables differ and the carry into half 1 depends on half 0. The arithmetic scenarios load unrelated random tables into each half and sweep all pins, including both chain inputs, over many vectors. Every combination of operand source and incoming carry is reached this way.

// File: rtl/flc_pkg.sv
package flc_pkg;

   // Register data source, one code per half.
   typedef enum logic [1:0] {
      SRC_LOGIC = 2'b00,
      SRC_SUM   = 2'b01,
      SRC_CHAIN = 2'b10,
      SRC_CHNX  = 2'b11
   } reg_src_e;

   localparam int HALVES = 2;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

endpackage

// File: rtl/flc_lut.sv
module flc_lut #(
   parameter int K = 6,
   localparam int N = 1 << K
) (
   input  logic [N-1:0] mask,
   input  logic [K-1:0] addr,
   output logic         f,
   output logic         op_a,
   output logic         op_b
);

   // Elaboration-time check on the table size.
   if (K < 3 || K > 8) begin : g_bad_k
      $error("flc_lut: K must lie in 3..8");
   end

   logic [K-2:0] sub;

   always_comb begin
      sub  = addr[K-2:0];
      f    = mask[addr];
      op_a = mask[{1'b0, sub}];
      op_b = mask[{1'b1, sub}];
   end

endmodule

// File: rtl/flc_adder.sv
module flc_adder (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   import flc_pkg::*;

   always_comb begin
      s  = a ^ b ^ ci;
      co = maj3(a, b, ci);
   end

endmodule

// File: rtl/flc_reg.sv
module flc_reg
   import flc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     sclr,
   input  reg_src_e src,
   input  logic     d_logic,
   input  logic     d_sum,
   input  logic     d_chain,
   output logic     q
);

   logic d_sel;

   always_comb begin
      unique case (src)
         SRC_LOGIC: d_sel = d_logic;
         SRC_SUM:   d_sel = d_sum;
         default:   d_sel = d_chain;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (sclr) q <= 1'b0;
      else if (en)   q <= d_sel;
   end

   // R9: clear wins over enable
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sclr |=> (q == 1'b0));

   // R10: no enable, no clear -> value kept
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !sclr) |=> $stable(q));

endmodule

// File: rtl/flc_cell.sv
module flc_cell
   import flc_pkg::*;
#(
   parameter int LUT_K = 6,
   localparam int N        = 1 << LUT_K,
   localparam int SH_W     = LUT_K - 2,
   localparam int ARITH_LO = 2 * N,
   localparam int RSRC_LO  = ARITH_LO + 2,
   localparam int OREG_LO  = RSRC_LO + 4,
   localparam int FUSE_BIT = OREG_LO + 2,
   localparam int SHR_BIT  = FUSE_BIT + 1,
   localparam int CFG_W    = SHR_BIT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic [SH_W-1:0]  din_s,
   input  logic [1:0]       din_e,
   input  logic [1:0]       din_f,
   input  logic             carry_in,
   output logic             carry_out,
   input  logic             share_in,
   output logic             share_out,
   input  logic             chain_in,
   output logic             chain_out,
   input  logic [1:0]       en,
   input  logic [1:0]       sclr,
   output logic [1:0]       y,
   output logic [1:0]       q
);

   if (LUT_K < 3 || LUT_K > 8) begin : g_bad_k
      $error("flc_cell: LUT_K must lie in 3..8");
   end

   logic             fuse_on;
   logic             share_on;
   logic [HALVES:0]  cy;          // carry ripple, cy[0] = carry_in
   logic [HALVES:0]  shc;         // share ripple, shc[0] = share_in
   logic [1:0]       lut_f, op_a, op_b, sum, lval, cval;

   assign fuse_on  = cfg[FUSE_BIT];
   assign share_on = cfg[SHR_BIT];
   assign cy[0]    = carry_in;
   assign shc[0]   = share_in;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [N-1:0]    tbl;
      logic [LUT_K-1:0] addr;
      logic            b_in;
      logic            chain_d;
      reg_src_e        src;

      assign tbl  = cfg[h*N +: N];
      assign addr = {din_f[h], din_e[h], din_s};
      assign src  = reg_src_e'(cfg[RSRC_LO + 2*h +: 2]);

      flc_lut #(.K(LUT_K)) u_lut (
         .mask(tbl), .addr(addr), .f(lut_f[h]), .op_a(op_a[h]), .op_b(op_b[h])
      );

      // Share chain: operand B is taken from the chain instead of the table.
      assign b_in     = share_on ? shc[h] : op_b[h];
      assign shc[h+1] = op_b[h];

      flc_adder u_add (
         .a(op_a[h]), .b(b_in), .ci(cy[h]), .s(sum[h]), .co(cy[h+1])
      );

      // Logic value: half 0 may be fused into a 7-input selection.
      if (h == 0) begin : g_fuse
         logic [LUT_K-1:0] addr_alt;
         logic [N-1:0]     tbl_alt;
         logic             alt_f;
         assign tbl_alt  = cfg[N +: N];
         assign addr_alt = {din_e[1], din_e[0], din_s};
         assign alt_f    = tbl_alt[addr_alt];
         assign lval[h]  = (fuse_on && din_f[1]) ? alt_f : lut_f[h];
      end else begin : g_plain
         assign lval[h] = lut_f[h];
      end

      assign cval[h] = cfg[ARITH_LO + h] ? sum[h] : lval[h];

      if (h == 0) begin : g_chain_head
         assign chain_d = chain_in;
      end else begin : g_chain_link
         assign chain_d = q[h-1];
      end

      flc_reg u_reg (
         .clk(clk), .rst_n(rst_n), .en(en[h]), .sclr(sclr[h]), .src(src),
         .d_logic(lval[h]), .d_sum(sum[h]), .d_chain(chain_d), .q(q[h])
      );

      assign y[h] = cfg[OREG_LO + h] ? q[h] : cval[h];
   end

   assign carry_out = cy[HALVES];
   assign share_out = share_on ? shc[HALVES] : 1'b0;
   assign chain_out = q[HALVES-1];

   // R8: two-stage shift through the register chain
   a_r8_chain_head: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[RSRC_LO+1] && en[0] && !sclr[0]) |=> (q[0] == $past(chain_in)));

   a_r8_chain_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[RSRC_LO+3] && en[1] && !sclr[1]) |=> (chain_out == $past(q[0])));

   // R1: registers sit at zero while reset is held
   a_r1_reset_zero: assert property (@(posedge clk)
      (!rst_n && !$isunknown(q)) |-> (q == 2'b00));

endmodule

// File: tb/flc_cell_test.sv
module flc_cell_test;

   localparam int K  = 6;
   localparam int N  = 1 << K;
   localparam int CW = 2 * N + 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] cfg;
   logic [K-3:0]  din_s;
   logic [1:0]    din_e, din_f, en, sclr, y, q;
   logic          carry_in, carry_out, share_in, share_out, chain_in, chain_out;

   // configuration fields kept by the bench
   logic [N-1:0] m0, m1;
   logic [1:0]   c_arith, c_oreg;
   logic [1:0]   c_src0, c_src1;
   logic         c_fuse, c_share;

   // expected values
   logic [1:0] e_lv, e_sum, e_q;
   logic       e_cout, e_shout;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   flc_cell #(.LUT_K(K)) uut (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .din_s(din_s), .din_e(din_e),
      .din_f(din_f), .carry_in(carry_in), .carry_out(carry_out),
      .share_in(share_in), .share_out(share_out), .chain_in(chain_in),
      .chain_out(chain_out), .en(en), .sclr(sclr), .y(y), .q(q)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic put_cfg();
      cfg = {c_share, c_fuse, c_oreg, c_src1, c_src0, c_arith, m1, m0};
   endtask

   function automatic logic maj(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   // Expected combinational values from the requirements
   task automatic model();
      logic [N-1:0] t [2];
      logic [1:0] oa, ob, lut;
      logic bb0, bb1, c1;
      t[0] = m0; t[1] = m1;
      for (int h = 0; h < 2; h++) begin
         lut[h] = t[h][{din_f[h], din_e[h], din_s}];
         oa[h]  = t[h][{1'b0, din_e[h], din_s}];
         ob[h]  = t[h][{1'b1, din_e[h], din_s}];
      end
      e_lv[0] = (c_fuse && din_f[1]) ? m1[{din_e[1], din_e[0], din_s}] : lut[0];
      e_lv[1] = lut[1];
      bb0 = c_share ? share_in : ob[0];
      bb1 = c_share ? ob[0]    : ob[1];
      e_sum[0] = oa[0] ^ bb0 ^ carry_in;
      c1       = maj(oa[0], bb0, carry_in);
      e_sum[1] = oa[1] ^ bb1 ^ c1;
      e_cout   = maj(oa[1], bb1, c1);
      e_shout  = c_share ? ob[1] : 1'b0;
   endtask

   function automatic logic next_q(input int h, input logic [1:0] src, input logic chn);
      if (sclr[h]) return 1'b0;
      if (!en[h])  return e_q[h];
      case (src)
         2'b00:   return e_lv[h];
         2'b01:   return e_sum[h];
         default: return chn;
      endcase
   endfunction

   // One clock edge: predict, clock, sample after the edge.
   task automatic step();
      logic [1:0] nq;
      model();
      nq[0] = next_q(0, c_src0, chain_in);
      nq[1] = next_q(1, c_src1, e_q[0]);
      @(posedge clk);
      #1;
      e_q = nq;
   endtask

   task automatic rand_pins();
      din_s = 4'($urandom); din_e = 2'($urandom); din_f = 2'($urandom);
      carry_in = 1'($urandom); share_in = 1'($urandom); chain_in = 1'($urandom);
   endtask

   task automatic base_cfg();
      c_arith = 0; c_oreg = 0; c_src0 = 0; c_src1 = 0; c_fuse = 0; c_share = 0;
      m0 = {$urandom, $urandom}; m1 = {$urandom, $urandom};
      put_cfg();
   endtask

   task automatic t_reset();
      rst_n = 0; en = 2'b11; sclr = 0; rand_pins(); chain_in = 1;
      base_cfg(); c_src0 = 2'b10; c_src1 = 2'b10; put_cfg();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 q in reset", {2'b0, q}, 4'h0);
      chk("R1 chain_out in reset", {3'b0, chain_out}, 4'h0);
      @(negedge clk);
      rst_n = 1; en = 0; e_q = 0;
   endtask

   task automatic t_logic();
      @(negedge clk); base_cfg();
      for (int i = 0; i < 40; i++) begin
         rand_pins(); #1; model();
         chk("R2 y0 logic", {3'b0, y[0]}, {3'b0, e_lv[0]});
         chk("R2 y1 logic", {3'b0, y[1]}, {3'b0, e_lv[1]});
      end
   endtask

   task automatic t_four();
      logic [15:0] p0, p1;
      p0 = 16'($urandom); p1 = 16'($urandom);
      base_cfg(); m0 = {4{p0}}; m1 = {4{p1}}; put_cfg();
      for (int s = 0; s < 16; s++) begin
         for (int ef = 0; ef < 16; ef += 5) begin
            din_s = 4'(s); din_e = ef[1:0]; din_f = ef[3:2]; #1;
            chk("R3 y0 ignores e/f", {3'b0, y[0]}, {3'b0, p0[s]});
            chk("R3 y1 ignores e/f", {3'b0, y[1]}, {3'b0, p1[s]});
         end
      end
   endtask

   task automatic t_fused();
      base_cfg(); c_fuse = 1; put_cfg();
      for (int i = 0; i < 40; i++) begin
         rand_pins(); #1; model();
         chk("R4 y0 fused", {3'b0, y[0]}, {3'b0, e_lv[0]});
         chk("R4 y1 unaffected", {3'b0, y[1]}, {3'b0, m1[{din_f[1], din_e[1], din_s}]});
      end
   endtask

   task automatic t_arith(input logic shr);
      base_cfg(); c_arith = 2'b11; c_share = shr; put_cfg();
      for (int i = 0; i < 60; i++) begin
         rand_pins(); #1; model();
         if (!shr) begin
            chk("R5 sum0", {3'b0, y[0]}, {3'b0, e_sum[0]});
            chk("R5 sum1", {3'b0, y[1]}, {3'b0, e_sum[1]});
            chk("R5 carry_out", {3'b0, carry_out}, {3'b0, e_cout});
            chk("R6 share_out off", {3'b0, share_out}, 4'h0);
         end else begin
            chk("R6 sum0 shared", {3'b0, y[0]}, {3'b0, e_sum[0]});
            chk("R6 sum1 shared", {3'b0, y[1]}, {3'b0, e_sum[1]});
            chk("R6 carry_out shared", {3'b0, carry_out}, {3'b0, e_cout});
            chk("R6 share_out", {3'b0, share_out}, {3'b0, e_shout});
         end
      end
   endtask

   task automatic t_regsrc();
      base_cfg(); c_src0 = 2'b00; c_src1 = 2'b01; c_fuse = 1; put_cfg();
      en = 2'b11; sclr = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); rand_pins(); step();
         chk("R7 q0 from logic", {3'b0, q[0]}, {3'b0, e_q[0]});
         chk("R7 q1 from sum", {3'b0, q[1]}, {3'b0, e_q[1]});
      end
      @(negedge clk); c_src0 = 2'b11; c_src1 = 2'b00; put_cfg();
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rand_pins(); step();
         chk("R7 q0 chain code 3", {3'b0, q[0]}, {3'b0, e_q[0]});
         chk("R7 q1 logic", {3'b0, q[1]}, {3'b0, e_q[1]});
      end
   endtask

   task automatic t_chain();
      @(negedge clk); base_cfg(); c_src0 = 2'b10; c_src1 = 2'b10; put_cfg();
      en = 2'b11; sclr = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk); rand_pins(); step();
         chk("R8 q0 shift", {3'b0, q[0]}, {3'b0, e_q[0]});
         chk("R8 chain_out shift", {3'b0, chain_out}, {3'b0, e_q[1]});
      end
   endtask

   task automatic t_clear_hold();
      @(negedge clk); base_cfg(); c_src0 = 2'b10; c_src1 = 2'b10; put_cfg();
      en = 2'b11; sclr = 0; chain_in = 1;
      step(); @(negedge clk); step();
      chk("R8 preload", {2'b0, q}, 4'h3);
      @(negedge clk); en = 2'b00; chain_in = 0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R10 hold", {2'b0, q}, {2'b0, e_q});
         @(negedge clk);
      end
      sclr = 2'b01; step();
      chk("R9 clear without enable q0", {3'b0, q[0]}, 4'h0);
      chk("R10 q1 held", {3'b0, q[1]}, 4'h1);
      @(negedge clk); en = 2'b11; sclr = 2'b10; chain_in = 1; step();
      chk("R9 clear beats enable", {3'b0, q[1]}, 4'h0);
      chk("R8 q0 loads while q1 clears", {3'b0, q[0]}, 4'h1);
      @(negedge clk); sclr = 0;
   endtask

   task automatic t_outsel();
      base_cfg(); c_oreg = 2'b11; c_src0 = 2'b00; c_src1 = 2'b01; c_arith = 2'b10;
      put_cfg(); en = 2'b11; sclr = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); rand_pins(); step();
         chk("R11 y0 registered", {3'b0, y[0]}, {3'b0, e_q[0]});
         chk("R11 y1 registered", {3'b0, y[1]}, {3'b0, e_q[1]});
         rand_pins(); #1;
         chk("R11 y0 steady mid-cycle", {3'b0, y[0]}, {3'b0, e_q[0]});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      e_q = 0;
      t_reset();
      t_logic();
      t_four();
      t_fused();
      t_arith(1'b0);
      t_arith(1'b1);
      t_regsrc();
      t_chain();
      t_clear_hold();
      t_outsel();
      finish_run();
   end

endmodule